// File: doc/BRIEF.md
# One-Hot Maximum-Value Finder

This block takes a flat bus of 256 unsigned 4-bit values and returns the largest of them as a 4-bit binary number. It does not compare values in pairs. Each value is first expanded into a 16-bit one-hot code. The codes of all values are merged bit by bit into one 16-bit presence mask, in which bit v is high when at least one value equals v. A highest-first priority arbiter keeps only the top set bit of that mask. An encoder then turns the winning bit back into binary.

The unit has no clock and no state, and its output follows any change on the input bus. Because at least one code is always present, the result is always defined and there is no separate valid flag. It reports which value is largest, not which lane held it. Each of the 16 bit-wise merges is a balanced tree of 4-input OR gates, four levels deep at the default size.

Top module: `onehot_max_finder`

## Requirements
- R1: The output equals the largest of the 256 lane values, where lane k occupies bits [4k+3:4k] of the input bus and is read as unsigned.
- R2: When every lane is zero, the output is 0.
- R3: When all lanes hold the same value v, the output is v, for each v from 0 to 15.
- R4: A single lane holding 15 among zero lanes gives 15, whether that lane is the lowest (lane 0) or the highest (lane 255).
- R5: A single largest value in lane 255, with every other lane holding smaller values, gives that value.
- R6: The output depends only on which values are present: reordering the lanes, or repeating a value, does not change it.
- R7: The output settles combinationally within the same cycle as an input change, with no clock edge in between.
- R8: When the present values leave gaps in the code range (for example only 3 and 9), the output is the highest present code and never an absent code above it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vals_i | input | 1024 | 256 packed unsigned 4-bit values; lane k at bits [4k+3:4k] |
| max_o | output | 4 | Largest value present on vals_i |

## Verification
Every result of this block is due in zero cycles: there is no register between vals_i and max_o, so the maximum is valid as soon as the combinational logic settles after a change. The bench applies each new input set on a falling clock edge. It samples max_o one nanosecond later, well before the next rising edge. One scenario changes the inputs while the clock is held between edges, and checks the new output before any edge has occurred. This shows that no register delays the result.

// File: rtl/maxfind_pkg.sv
package maxfind_pkg;

    // Default geometry of the finder
    localparam int unsigned LANES_DEF = 256;
    localparam int unsigned VAL_W_DEF = 4;

    // Levels of a 4-ary reduction tree over a power-of-four leaf count
    function automatic int unsigned quad_levels(input int unsigned leaves);
        return $clog2(leaves) / 2;
    endfunction

endpackage

// File: rtl/onehot_dec.sv
module onehot_dec #(
    parameter int unsigned IN_W = 4
) (
    input  logic [IN_W-1:0]       bin_i,
    output logic [(1<<IN_W)-1:0]  oh_o
);
    localparam int unsigned CODES = 1 << IN_W;

    always_comb begin
        oh_o = '0;
        for (int v = 0; v < CODES; v++) begin
            if (bin_i == IN_W'(v)) oh_o[v] = 1'b1;
        end
    end

    always_comb begin
        // R1
        dec_onehot_chk: assert ($onehot(oh_o))
            else $error("decoder output not one-hot");
    end
endmodule

// File: rtl/or4_tree.sv
module or4_tree #(
    parameter int unsigned LEAVES = 256
) (
    input  logic [LEAVES-1:0] bits_i,
    output logic              any_o
);
    localparam int unsigned LEVELS = maxfind_pkg::quad_levels(LEAVES);

    for (genvar l = 0; l <= LEVELS; l++) begin : lvl_g
        localparam int unsigned W = LEAVES >> (2 * l);
        logic [W-1:0] node;
        if (l == 0) begin : g_leaf
            assign node = bits_i;
        end else begin : g_or
            for (genvar j = 0; j < W; j++) begin : g_n
                assign node[j] = |lvl_g[l-1].node[4*j +: 4];
            end
        end
    end

    assign any_o = lvl_g[LEVELS].node[0];

    always_comb begin
        // R6
        tree_any_chk: assert (any_o == (bits_i != '0))
            else $error("reduction tree disagrees with its leaves");
    end
endmodule

// File: rtl/hi_arbiter.sv
module hi_arbiter #(
    parameter int unsigned N = 16
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o
);
    logic none_above;

    always_comb begin
        none_above = 1'b1;
        for (int i = N - 1; i >= 0; i--) begin
            gnt_o[i]   = req_i[i] & none_above;
            none_above = none_above & ~req_i[i];
        end
    end

    always_comb begin
        // R8
        gnt_subset_chk: assert ((gnt_o & ~req_i) == '0)
            else $error("grant without request");
        // R8
        gnt_single_chk: assert ((req_i != '0) == $onehot(gnt_o))
            else $error("grant count wrong");
        // R8
        gnt_highest_chk: assert ((req_i & ~((gnt_o << 1) - N'(1))) == '0 || gnt_o == '0)
            else $error("request above the grant");
    end
endmodule

// File: rtl/onehot_enc.sv
module onehot_enc #(
    parameter int unsigned W = 4
) (
    input  logic [(1<<W)-1:0] oh_i,
    output logic [W-1:0]      bin_o
);
    localparam int unsigned N = 1 << W;

    always_comb begin
        bin_o = '0;
        for (int i = 0; i < N; i++) begin
            if (oh_i[i]) bin_o = bin_o | W'(i);
        end
    end

    always_comb begin
        // R1
        enc_roundtrip_chk: assert (!$onehot(oh_i) || oh_i[bin_o])
            else $error("encoder output does not point at the set bit");
    end
endmodule

// File: rtl/onehot_max_finder.sv
module onehot_max_finder #(
    parameter int unsigned LANES = maxfind_pkg::LANES_DEF,
    parameter int unsigned VAL_W = maxfind_pkg::VAL_W_DEF
) (
    input  logic [LANES*VAL_W-1:0] vals_i,
    output logic [VAL_W-1:0]       max_o
);
    localparam int unsigned CODES = 1 << VAL_W;

    logic [CODES-1:0] lane_oh [LANES];
    logic [LANES-1:0] code_col [CODES];
    logic [CODES-1:0] present;
    logic [CODES-1:0] winner;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        onehot_dec #(.IN_W(VAL_W)) u_dec (
            .bin_i (vals_i[k*VAL_W +: VAL_W]),
            .oh_o  (lane_oh[k])
        );
    end

    always_comb begin
        for (int v = 0; v < CODES; v++) begin
            for (int k = 0; k < LANES; k++) begin
                code_col[v][k] = lane_oh[k][v];
            end
        end
    end

    for (genvar v = 0; v < CODES; v++) begin : g_code
        or4_tree #(.LEAVES(LANES)) u_or (
            .bits_i (code_col[v]),
            .any_o  (present[v])
        );
    end

    hi_arbiter #(.N(CODES)) u_arb (
        .req_i (present),
        .gnt_o (winner)
    );

    onehot_enc #(.W(VAL_W)) u_enc (
        .oh_i  (winner),
        .bin_o (max_o)
    );

    always_comb begin
        // R2
        mask_nonempty_chk: assert (present != '0)
            else $error("presence mask empty");
        // R1
        max_present_chk: assert (present[max_o])
            else $error("result code not present");
        // R8
        nothing_above_chk: assert ((present >> max_o) == CODES'(1))
            else $error("present code above result");
    end
endmodule

// File: tb/tb_onehot_max_finder.sv
`timescale 1ns/1ps
module tb_onehot_max_finder;
    localparam int unsigned LANES = 256;
    localparam int unsigned VW    = 4;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [LANES*VW-1:0]   vals;
    logic [VW-1:0]         max_w;
    int                    n_run = 0;
    int                    n_fail = 0;
    bit                    done = 0;

    always #4 clk = ~clk;

    onehot_max_finder dut (
        .vals_i (vals),
        .max_o  (max_w)
    );

    function automatic logic [VW-1:0] ref_max(input logic [LANES*VW-1:0] b);
        logic [VW-1:0] m = '0;
        for (int k = 0; k < LANES; k++)
            if (b[k*VW +: VW] > m) m = b[k*VW +: VW];
        return m;
    endfunction

    task automatic check(input string req, input logic [VW-1:0] got, input logic [VW-1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic apply(input logic [LANES*VW-1:0] b);
        @(negedge clk);
        vals = b;
        #1;
    endtask

    task automatic t_reset;
        vals = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        check("R2 reset state", max_w, 4'd0);
    endtask

    task automatic t_all_zero;
        apply('0);
        check("R2 all zero", max_w, 4'd0);
    endtask

    task automatic t_all_equal;
        for (int v = 0; v < 16; v++) begin
            logic [LANES*VW-1:0] b;
            for (int k = 0; k < LANES; k++) b[k*VW +: VW] = VW'(v);
            apply(b);
            check("R3 all equal", max_w, VW'(v));
        end
    endtask

    task automatic t_single15;
        logic [LANES*VW-1:0] b;
        b = '0; b[3:0] = 4'hF;
        apply(b);
        check("R4 fifteen at lane 0", max_w, 4'hF);
        b = '0; b[LANES*VW-1 -: VW] = 4'hF;
        apply(b);
        check("R4 fifteen at lane 255", max_w, 4'hF);
    endtask

    task automatic t_last_lane;
        logic [LANES*VW-1:0] b;
        for (int k = 0; k < LANES; k++) b[k*VW +: VW] = VW'(k % 7);
        b[LANES*VW-1 -: VW] = 4'd9;
        apply(b);
        check("R5 largest in last lane", max_w, 4'd9);
    endtask

    task automatic t_gaps;
        logic [LANES*VW-1:0] b;
        for (int k = 0; k < LANES; k++) b[k*VW +: VW] = (k % 5 == 2) ? 4'd9 : 4'd3;
        apply(b);
        check("R8 only 3 and 9", max_w, 4'd9);
        b = '0; b[100*VW +: VW] = 4'd12; b[7*VW +: VW] = 4'd1;
        apply(b);
        check("R8 sparse 0 1 12", max_w, 4'd12);
    endtask

    task automatic t_perm;
        for (int r = 0; r < 8; r++) begin
            logic [LANES*VW-1:0] b, rb;
            for (int k = 0; k < LANES; k++) b[k*VW +: VW] = VW'($urandom_range(0, 10 + r));
            for (int k = 0; k < LANES; k++) rb[k*VW +: VW] = b[(LANES-1-k)*VW +: VW];
            apply(b);
            check("R6 original order", max_w, ref_max(b));
            apply(rb);
            check("R6 reversed order", max_w, ref_max(b));
        end
    endtask

    task automatic t_random;
        for (int r = 0; r < 200; r++) begin
            logic [LANES*VW-1:0] b;
            int cap = r % 16;
            for (int k = 0; k < LANES; k++) b[k*VW +: VW] = VW'($urandom_range(0, cap));
            apply(b);
            check("R1 random set", max_w, ref_max(b));
        end
    endtask

    task automatic t_comb;
        logic [LANES*VW-1:0] b;
        @(posedge clk);
        #1;
        b = '0; b[50*VW +: VW] = 4'd6;
        vals = b;
        #1;
        check("R7 settles without edge (6)", max_w, 4'd6);
        b[51*VW +: VW] = 4'd13;
        vals = b;
        #1;
        check("R7 settles without edge (13)", max_w, 4'd13);
    endtask

    initial begin
        t_reset();
        t_all_zero();
        t_all_equal();
        t_single15();
        t_last_lane();
        t_gaps();
        t_perm();
        t_random();
        t_comb();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule